// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of peripheral request lines and a processor. It records each request in a per-line pending bit, and it keeps an enable bit and a 4-bit priority for every line. Each cycle it picks the strongest pending, enabled line and offers it to the processor as a vector number and a table address. Software changes the per-line settings through a one-cycle register write port.

The controller keeps a stack of the priorities of the handlers in progress. A new request interrupts the running handler only when its priority is strictly stronger. Weaker and equal requests wait until a return. When a handler returns while an eligible request is waiting, the controller flags a direct chain into that handler instead of a drop to base level. The offered vector follows the strongest request right up to the cycle the processor accepts it. A request that appears during the entry window therefore redirects the entry. A global mask stops every dispatch but does not stop pending bits from collecting.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset no line is pending or enabled, every priority reads 15, no handler is active, and `cpuReq` and `tailChain` are low.
- R2: A register write (`regWrEn` high for one cycle) acts on line `regIdx` according to `regOp`: 0 enables it, 1 disables it, 2 loads `regPrio` as its priority, and 3 clears its pending bit. The change is seen from the next cycle.
- R3: Any cycle a line is high while it is not in service sets its pending bit. The bit stays set until that line is entered or cleared by software. A clear in a cycle where the line is still high has no lasting effect.
- R4: The offered line is the pending, enabled line with the numerically lowest priority (0 strongest, 15 weakest). Among equal priorities the lower line number wins.
- R5: `vecNum` is 16 plus the offered line number, and `vecAddr` is `VEC_BASE` plus 4 times `vecNum`.
- R6: While a handler is active, `cpuReq` is raised only for a request whose priority is strictly lower in value than the active priority. An `entryAck` while `cpuReq` is high pushes the new priority and clears that line's pending bit.
- R7: A request of equal or weaker priority than the active handler stays pending and is offered once the handlers above it have returned.
- R8: While `globalMask` is high, `cpuReq` and `tailChain` stay low, and pending bits keep being set.
- R9: In a `returnAck` cycle, `tailChain` is high exactly when a pending, enabled, unmasked request would be eligible against the priority that the return restores (any request at base level).
- R10: The vector taken at `entryAck` is the one offered in that same cycle. A stronger request that arrives after `cpuReq` rose, but before the entry, replaces the earlier one.
- R11: Up to `STACK_DEPTH` (default 4) handlers nest. A return restores the interrupted handler's priority, or no active priority at base level. With the stack full, `cpuReq` stays low.
- R12: A line in service is never pending. If its source is still high when its handler returns, the line is pending again from the next cycle.
- R13: A disabled line still collects pending state but is never offered. Enabling it later makes it eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqLines | input | NUM_LINES | Level request lines from peripherals |
| globalMask | input | 1 | Blocks all dispatch while high |
| entryAck | input | 1 | Processor enters the offered handler |
| returnAck | input | 1 | Processor returns from the current handler |
| regWrEn | input | 1 | Register write strobe |
| regOp | input | 2 | Write operation: 0 enable, 1 disable, 2 priority, 3 clear pending |
| regIdx | input | 8 | Target line of the write |
| regPrio | input | PRIO_W | Priority value for operation 2 |
| cpuReq | output | 1 | Interrupt request to the processor |
| vecNum | output | 8 | Vector number of the offered line |
| vecAddr | output | 32 | Table address of the offered vector |
| tailChain | output | 1 | Return chains straight into the next handler |

## Verification
The bench drives single pulses, which separate pending capture from arbitration. Two simultaneous pulses at one priority show whether ties resolve by line number. Stronger, equal and weaker arrivals over an active handler tell preemption apart from queuing. Returns with requests waiting at different depths show whether tail-chaining is judged against the restored priority rather than the popped one. A held level line shows re-pending at return. A stronger pulse between request and entry shows late-arrival redirection. Masked, disabled and software-cleared pulses show that pending state is kept or dropped as the requirements say.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int LINE_IDX_W = 8;

  typedef enum logic [1:0] {
    OP_ENABLE  = 2'd0,
    OP_DISABLE = 2'd1,
    OP_PRIO    = 2'd2,
    OP_CLEAR   = 2'd3
  } reg_op_e;

  typedef struct packed {
    logic                  takeEn;
    logic [LINE_IDX_W-1:0] takeIdx;
    logic                  retEn;
    logic [LINE_IDX_W-1:0] retIdx;
  } strobe_t;
endpackage

// File: rtl/nic_lines.sv
module nic_lines
  import nic_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int PRIO_W    = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LINES-1:0]              irqLines,
  input  logic                              regWrEn,
  input  logic [1:0]                        regOp,
  input  logic [LINE_IDX_W-1:0]             regIdx,
  input  logic [PRIO_W-1:0]                 regPrio,
  input  strobe_t                           strb,
  output logic [NUM_LINES-1:0]              pendQ,
  output logic [NUM_LINES-1:0]              enQ,
  output logic [NUM_LINES-1:0][PRIO_W-1:0]  prioQ
);
  logic [NUM_LINES-1:0] inSvcQ;
  logic [NUM_LINES-1:0] takeMask;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic hit, takeI, retI, clrI, setI;
    assign hit   = regWrEn && (regIdx == LINE_IDX_W'(i));
    assign takeI = strb.takeEn && (strb.takeIdx == LINE_IDX_W'(i));
    assign retI  = strb.retEn && (strb.retIdx == LINE_IDX_W'(i));
    assign clrI  = hit && (regOp == OP_CLEAR);
    assign setI  = irqLines[i] && !inSvcQ[i] && !takeI;
    assign takeMask[i] = takeI;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pendQ[i]  <= 1'b0;
        enQ[i]    <= 1'b0;
        prioQ[i]  <= '1;
        inSvcQ[i] <= 1'b0;
      end else begin
        pendQ[i] <= (pendQ[i] && !takeI && !clrI) || setI;
        if (hit && regOp == OP_ENABLE)  enQ[i] <= 1'b1;
        if (hit && regOp == OP_DISABLE) enQ[i] <= 1'b0;
        if (hit && regOp == OP_PRIO)    prioQ[i] <= regPrio;
        if (takeI)     inSvcQ[i] <= 1'b1;
        else if (retI) inSvcQ[i] <= 1'b0;
      end
    end

    // R3: a pending bit is only lost through entry or a software clear
    p_pend_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pendQ[i] && !takeI && !clrI) |=> pendQ[i]);
    // R12: a line being serviced cannot also be pending
    p_svc_not_pend_r12: assert property (@(posedge clk) disable iff (!rst_n)
      inSvcQ[i] |-> !pendQ[i]);
  end

  // R10: at most one line is entered per cycle
  p_single_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(takeMask));
endmodule

// File: rtl/nic_ctrl.sv
module nic_ctrl
  import nic_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int PRIO_W      = 4,
  parameter int STACK_DEPTH = 4,
  localparam int IDX_W      = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int DEPTH_W    = $clog2(STACK_DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_LINES-1:0]              pendQ,
  input  logic [NUM_LINES-1:0]              enQ,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0]  prioQ,
  input  logic                              globalMask,
  input  logic                              entryAck,
  input  logic                              returnAck,
  output strobe_t                           strb,
  output logic                              cpuReq,
  output logic [IDX_W-1:0]                  winIdx,
  output logic                              tailChain
);
  logic               found;
  logic [PRIO_W-1:0]  winPrio;
  logic [PRIO_W-1:0]  stkPrio [STACK_DEPTH];
  logic [IDX_W-1:0]   stkIdx  [STACK_DEPTH];
  logic [DEPTH_W-1:0] depthQ;
  logic [PRIO_W-1:0]  topPrio, belowPrio;
  logic [IDX_W-1:0]   topIdx;
  logic               takeEn, retEn;

  // strongest pending, enabled line; strict compare keeps lower index on ties
  always_comb begin
    found   = 1'b0;
    winIdx  = '0;
    winPrio = '1;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (pendQ[i] && enQ[i] && (!found || prioQ[i] < winPrio)) begin
        found   = 1'b1;
        winIdx  = IDX_W'(i);
        winPrio = prioQ[i];
      end
    end
  end

  always_comb begin
    topPrio   = '1;
    belowPrio = '1;
    topIdx    = '0;
    for (int k = 0; k < STACK_DEPTH; k++) begin
      if (int'(depthQ) == k + 1) begin
        topPrio = stkPrio[k];
        topIdx  = stkIdx[k];
      end
      if (int'(depthQ) == k + 2) belowPrio = stkPrio[k];
    end
  end

  assign cpuReq = found && !globalMask && (int'(depthQ) < STACK_DEPTH) &&
                  ((depthQ == '0) || (winPrio < topPrio));
  assign takeEn = entryAck && cpuReq;
  assign retEn  = returnAck && (depthQ != '0) && !takeEn;
  assign tailChain = retEn && found && !globalMask &&
                     ((depthQ == DEPTH_W'(1)) || (winPrio < belowPrio));

  assign strb.takeEn  = takeEn;
  assign strb.takeIdx = LINE_IDX_W'(winIdx);
  assign strb.retEn   = retEn;
  assign strb.retIdx  = LINE_IDX_W'(topIdx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depthQ <= '0;
      for (int k = 0; k < STACK_DEPTH; k++) begin
        stkPrio[k] <= '0;
        stkIdx[k]  <= '0;
      end
    end else if (takeEn) begin
      for (int k = 0; k < STACK_DEPTH; k++) begin
        if (int'(depthQ) == k) begin
          stkPrio[k] <= winPrio;
          stkIdx[k]  <= winIdx;
        end
      end
      depthQ <= depthQ + 1'b1;
    end else if (retEn) begin
      depthQ <= depthQ - 1'b1;
    end
  end

  // R6: entering over an active handler always strengthens the active priority
  p_strict_preempt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (takeEn && depthQ != '0) |=> (topPrio < $past(topPrio)));
  // R8: the global mask silences both dispatch outputs
  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
    globalMask |-> (!cpuReq && !tailChain));
  // R11: nesting never exceeds the stack
  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    int'(depthQ) <= STACK_DEPTH);
  // R11: a return pops exactly one level
  p_return_pops_r11: assert property (@(posedge clk) disable iff (!rst_n)
    retEn |=> (depthQ == $past(depthQ) - 1'b1));
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int          NUM_LINES   = 8,
  parameter int          PRIO_W      = 4,
  parameter int          STACK_DEPTH = 4,
  parameter logic [31:0] VEC_BASE    = 32'h0000_0400,
  localparam int         IDX_W       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int         VEC_OFFSET  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  irqLines,
  input  logic                  globalMask,
  input  logic                  entryAck,
  input  logic                  returnAck,
  input  logic                  regWrEn,
  input  logic [1:0]            regOp,
  input  logic [7:0]            regIdx,
  input  logic [PRIO_W-1:0]     regPrio,
  output logic                  cpuReq,
  output logic [7:0]            vecNum,
  output logic [31:0]           vecAddr,
  output logic                  tailChain
);
  strobe_t                             strb;
  logic [NUM_LINES-1:0]                pendQ, enQ;
  logic [NUM_LINES-1:0][PRIO_W-1:0]    prioQ;
  logic [IDX_W-1:0]                    winIdx;

  nic_lines #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)) u_lines (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .regWrEn(regWrEn),
    .regOp(regOp), .regIdx(regIdx), .regPrio(regPrio), .strb(strb),
    .pendQ(pendQ), .enQ(enQ), .prioQ(prioQ)
  );

  nic_ctrl #(.NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W), .STACK_DEPTH(STACK_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pendQ(pendQ), .enQ(enQ), .prioQ(prioQ),
    .globalMask(globalMask), .entryAck(entryAck), .returnAck(returnAck),
    .strb(strb), .cpuReq(cpuReq), .winIdx(winIdx), .tailChain(tailChain)
  );

  assign vecNum  = 8'(VEC_OFFSET) + 8'(winIdx);
  assign vecAddr = VEC_BASE + (32'(vecNum) << 2);
endmodule

// File: tb/nested_irq_ctrl_test.sv
module nested_irq_ctrl_test;
  localparam int N = 8;
  localparam int DEPTH = 4;
  localparam logic [31:0] BASE = 32'h0000_0400;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irqLines = '0;
  logic globalMask = 1'b0, entryAck = 1'b0, returnAck = 1'b0, regWrEn = 1'b0;
  logic [1:0] regOp = 2'd0;
  logic [7:0] regIdx = 8'd0;
  logic [3:0] regPrio = 4'd0;
  logic cpuReq, tailChain;
  logic [7:0] vecNum;
  logic [31:0] vecAddr;

  int checks = 0, fails = 0;
  string tag = "R1";

  // reference state
  bit mPend[N], mEn[N], mSvc[N];
  int mPrio[N];
  int stkP[$], stkI[$];
  int b;
  bit elig, take, ret;
  bit nPend[N];

  always #5 clk = ~clk;

  nested_irq_ctrl #(.NUM_LINES(N), .STACK_DEPTH(DEPTH), .VEC_BASE(BASE)) uut (
    .clk(clk), .rst_n(rst_n), .irqLines(irqLines), .globalMask(globalMask),
    .entryAck(entryAck), .returnAck(returnAck), .regWrEn(regWrEn),
    .regOp(regOp), .regIdx(regIdx), .regPrio(regPrio), .cpuReq(cpuReq),
    .vecNum(vecNum), .vecAddr(vecAddr), .tailChain(tailChain)
  );

  function automatic int bestLine();
    int best = -1;
    for (int i = 0; i < N; i++)
      if (mPend[i] && mEn[i] && (best < 0 || mPrio[i] < mPrio[best])) best = i;
    return best;
  endfunction

  function automatic bit eligible(int bl);
    if (bl < 0 || globalMask || stkP.size() >= DEPTH) return 0;
    if (stkP.size() == 0) return 1;
    return mPrio[bl] < stkP[stkP.size()-1];
  endfunction

  function automatic bit chainExp(int bl);
    if (!returnAck || entryAck || stkP.size() == 0 || bl < 0 || globalMask) return 0;
    if (stkP.size() == 1) return 1;
    return mPrio[bl] < stkP[stkP.size()-2];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        mPend[i] = 0; mEn[i] = 0; mSvc[i] = 0; mPrio[i] = 15;
      end
      stkP.delete(); stkI.delete();
    end else begin
      b = bestLine();
      elig = eligible(b);
      take = entryAck && elig;
      ret = returnAck && stkP.size() > 0 && !take;
      for (int i = 0; i < N; i++) begin
        bit tk, cl;
        tk = take && (b == i);
        cl = regWrEn && regOp == 2'd3 && regIdx == 8'(i);
        nPend[i] = (mPend[i] && !tk && !cl) || (irqLines[i] && !mSvc[i] && !tk);
      end
      for (int i = 0; i < N; i++) mPend[i] = nPend[i];
      if (take) begin
        mSvc[b] = 1; stkP.push_back(mPrio[b]); stkI.push_back(b);
      end else if (ret) begin
        mSvc[stkI[stkI.size()-1]] = 0;
        void'(stkP.pop_back()); void'(stkI.pop_back());
      end
      if (regWrEn && regIdx < N) begin
        case (regOp)
          2'd0: mEn[regIdx] = 1;
          2'd1: mEn[regIdx] = 0;
          2'd2: mPrio[regIdx] = int'(regPrio);
          default: ;
        endcase
      end
    end
  end

  task automatic check1(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compareOut();
    int bl;
    bit er, ec;
    bl = rst_n ? bestLine() : -1;
    er = rst_n ? eligible(bl) : 0;
    ec = rst_n ? chainExp(bl) : 0;
    check1("cpuReq", cpuReq, er);
    check1("tailChain", tailChain, ec);
    if (er || ec) begin
      check1("vecNum", vecNum, 16 + bl);
      check1("vecAddr", vecAddr, BASE + 4 * (16 + bl));
    end
  endtask

  task automatic tick(string t);
    tag = t;
    #2;
    compareOut();
    @(posedge clk);
    #1;
  endtask

  task automatic regWrite(logic [1:0] op, int idx, int p, string t);
    regWrEn = 1; regOp = op; regIdx = 8'(idx); regPrio = 4'(p);
    tick(t);
    regWrEn = 0;
  endtask

  task automatic pulse(int ln, string t);
    irqLines[ln] = 1; tick(t); irqLines[ln] = 0;
  endtask

  task automatic enter(string t);
    entryAck = 1; tick(t); entryAck = 0;
  endtask

  task automatic leave(string t);
    returnAck = 1; tick(t); returnAck = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: outputs idle during and right after reset
    repeat (2) tick("R1");
    rst_n = 1;
    tick("R1");
    pulse(2, "R1"); tick("R1");  // not enabled yet: nothing offered
    // R2: enable all lines and load priorities
    for (int i = 0; i < N; i++) regWrite(2'd0, i, 0, "R2");
    regWrite(2'd2, 3, 5, "R2"); regWrite(2'd2, 1, 5, "R2");
    regWrite(2'd2, 2, 2, "R2"); regWrite(2'd2, 4, 7, "R2");
    regWrite(2'd2, 6, 7, "R2"); regWrite(2'd2, 5, 9, "R2");
    regWrite(2'd2, 0, 1, "R2"); regWrite(2'd2, 7, 3, "R2");
    tick("R4");               // line 2 pending from the earlier pulse
    enter("R6"); leave("R9"); tick("R5");
    // R3/R5: single pulse then entry
    pulse(3, "R3"); tick("R5"); enter("R6");
    // R7: equal priority waits
    pulse(1, "R7"); tick("R7"); tick("R7");
    // R6: stronger preempts
    pulse(2, "R6"); enter("R6");
    leave("R9"); tick("R7");  // back to line 3, line 1 still waits
    leave("R9");              // base level: chain into line 1
    enter("R7"); leave("R9");
    // R4: tie resolved by lower line number
    irqLines[4] = 1; irqLines[6] = 1; tick("R4");
    irqLines[4] = 0; irqLines[6] = 0;
    enter("R4"); leave("R9"); enter("R4"); leave("R9");
    // R8: global mask blocks but pending accumulates
    globalMask = 1;
    pulse(5, "R8"); tick("R8"); returnAck = 1; tick("R8"); returnAck = 0;
    globalMask = 0; tick("R8");
    // R10: late arrival redirects the entry
    pulse(0, "R10"); enter("R10"); leave("R9"); enter("R10"); leave("R9");
    // R11: fill the nest stack
    regWrite(2'd2, 6, 0, "R11");
    pulse(4, "R11"); enter("R11");
    pulse(1, "R11"); enter("R11");
    pulse(7, "R11"); enter("R11");
    pulse(0, "R11"); enter("R11");
    pulse(6, "R11"); tick("R11"); enter("R11"); tick("R11");
    leave("R11"); enter("R11"); leave("R11");
    leave("R11"); tick("R11"); leave("R11"); leave("R11"); leave("R11");
    tick("R11");
    // R12: held level re-pends after return
    irqLines[7] = 1; tick("R12"); enter("R12");
    tick("R12"); tick("R12");
    leave("R12"); tick("R12"); tick("R12");
    irqLines[7] = 0; enter("R12"); leave("R12"); tick("R12");
    // R13: disabled line collects pending but is not offered
    regWrite(2'd1, 5, 0, "R13");
    pulse(5, "R13"); tick("R13"); tick("R13");
    regWrite(2'd0, 5, 0, "R13"); tick("R13");
    enter("R13"); leave("R13");
    // R3: software clear drops a pending bit
    pulse(2, "R3"); regWrite(2'd3, 2, 0, "R3"); tick("R3");
    // R3: clear while the line is still high does not stick
    irqLines[3] = 1; tick("R3"); regWrite(2'd3, 3, 0, "R3"); tick("R3");
    irqLines[3] = 0; enter("R3"); leave("R3"); tick("R3");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule